// File: doc/BRIEF.md
# Reset Sequencer with Sticky Cause Flags

This block decides when the processor core may leave reset. Four causes start a reset sequence: a low level on the board reset pin, a low-supply indication, a watchdog trip and an illegal-opcode trap. Each sequence has two parts. First comes a pin phase of at least `PHASE_CYC` clock cycles. During this phase an internally caused reset pulls the shared reset pin low, so the rest of the board is reset too. Then comes a settling count whose length depends on the clock source. When the count ends, the core reset is released and a one-cycle pulse tells the core that it may fetch its reset vector.

The pin phase is stretched for as long as its cause is still present. A low-supply reset holds the phase while the supply indication stays high. A pin reset holds it while the sensed pin stays low. The pin is sensed through a two-flop synchroniser. The block never drives the pin during a pin-caused reset, so the sensed level always reflects the outside world.

Two sticky cause flags can be read by software. A low-supply reset sets the supply flag and forces the watchdog flag clear. A watchdog reset sets the watchdog flag. The flags survive all later resets, except the power-on reset, until software clears them. Power-on itself behaves as a low-supply reset.

Top module: `rst_sequencer`

## Requirements
- R1: While the core runs, a request from any source starts a sequence at the next clock edge (a pin request arrives two edges later through the synchroniser). When the supply indication and a watchdog trip come in the same cycle, the supply cause wins and the flags read 2'b10.
- R2: For a watchdog or illegal-opcode cause, `pin_drive_n_o` is low for exactly `PHASE_CYC` cycles.
- R3: For a low-supply cause held high for H cycles, `pin_drive_n_o` is low for max(`PHASE_CYC`, H) cycles.
- R4: For a pin cause held low for W cycles, `pin_drive_n_o` stays high, and the core reset stays low for max(`PHASE_CYC`, W) plus the settling count.
- R5: After the pin phase, the core reset stays low for `STAB_SHORT` cycles when `osc_is_resonator_i`=0, and for `STAB_LONG` cycles when it is 1.
- R6: `vec_fetch_o` is high for exactly one cycle, namely the first cycle in which `core_rst_n_o` is high.
- R7: Flag bit 1 is the supply flag and bit 0 is the watchdog flag. While `lvd_i` is high, the flags become 2'b10 one edge later.
- R8: A watchdog reset sets bit 0 and leaves bit 1 unchanged. Pin and illegal-opcode resets change neither bit, and set flags persist across those resets.
- R9: A write with `flg_wr_i`=1 clears each flag whose data bit is 0. A data bit of 1 leaves its flag unchanged.
- R10: Watchdog and illegal-opcode requests are ignored while the core reset is asserted. They change neither the timing nor the flags.
- R11: A supply indication during the settling count restarts the pin phase with the supply cause.
- R12: While `por_n` is low, the core reset and the pin drive are low and the flags read 2'b10. After release, a full supply-cause sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| lvd_i | input | 1 | Low-supply indication, active high level |
| wdg_trip_i | input | 1 | Watchdog timeout request |
| bad_op_i | input | 1 | Illegal-opcode request |
| pin_sense_n_i | input | 1 | Sensed level of the reset pin (low means reset) |
| osc_is_resonator_i | input | 1 | 1: resonator clock (long settle), 0: RC or external clock (short settle) |
| flg_wr_i | input | 1 | Flag write strobe |
| flg_wdata_i | input | 2 | Flag write data, 0 clears |
| pin_drive_n_o | output | 1 | Open-drain pull-down of the reset pin, 0 pulls low |
| core_rst_n_o | output | 1 | Core reset, active low |
| vec_fetch_o | output | 1 | One-cycle reset-vector fetch strobe |
| flg_rdata_o | output | 2 | Flags: bit 1 supply, bit 0 watchdog |

## Verification
The bench builds the block with `PHASE_CYC`=20, `STAB_SHORT`=32 and `STAB_LONG`=64. With these values, both settling lengths and stretched phases fit in a short run. A held cause of 45 or 50 cycles can then clearly outlast the minimum phase, and a restart during the settling count lands well inside its window. The pin-sense settle window of 4 cycles stays smaller than both settling lengths, so the echo of the block's own pin drive is masked in every configuration the bench uses.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int PHASE_CYC  = 240,
  parameter int STAB_SHORT = 256,
  parameter int STAB_LONG  = 4096,
  parameter int PIN_SETTLE = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       lvd_i,
  input  logic       wdg_trip_i,
  input  logic       bad_op_i,
  input  logic       pin_sense_n_i,
  input  logic       osc_is_resonator_i,
  input  logic       flg_wr_i,
  input  logic [1:0] flg_wdata_i,
  output logic       pin_drive_n_o,
  output logic       core_rst_n_o,
  output logic       vec_fetch_o,
  output logic [1:0] flg_rdata_o
);
  localparam int MAXC = (PHASE_CYC > STAB_LONG) ?
                        ((PHASE_CYC > STAB_SHORT) ? PHASE_CYC : STAB_SHORT) :
                        ((STAB_LONG > STAB_SHORT) ? STAB_LONG : STAB_SHORT);
  localparam int CW = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] PH_LAST = CW'(PHASE_CYC - 1);
  localparam logic [CW-1:0] SS_LAST = CW'(STAB_SHORT - 1);
  localparam logic [CW-1:0] SL_LAST = CW'(STAB_LONG - 1);
  localparam logic [CW-1:0] SETTLE  = CW'(PIN_SETTLE);

  typedef enum logic [1:0] {S_RUN, S_PHASE, S_STAB} st_t;
  typedef enum logic [1:0] {C_PIN, C_LV, C_WDG, C_ILL} cause_t;

  st_t           st;
  cause_t        cause, req_cause;
  logic [CW-1:0] cnt, stab_last;
  logic [1:0]    pin_sync, flags, flags_nxt;
  logic          ext_low, req_any, hold, vec_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pin_sync <= 2'b11;
    else        pin_sync <= {pin_sync[0], pin_sense_n_i};

  assign ext_low   = ~pin_sync[1];
  assign req_any   = lvd_i | wdg_trip_i | bad_op_i | ext_low;
  assign req_cause = lvd_i ? C_LV : wdg_trip_i ? C_WDG : bad_op_i ? C_ILL : C_PIN;
  assign hold      = (cause == C_LV && lvd_i) || (cause == C_PIN && ext_low);
  assign stab_last = osc_is_resonator_i ? SL_LAST : SS_LAST;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_PHASE;
      cause <= C_LV;
      cnt   <= '0;
      vec_q <= 1'b0;
    end else begin
      vec_q <= 1'b0;
      unique case (st)
        S_RUN:
          if (req_any) begin
            st    <= S_PHASE;
            cause <= req_cause;
            cnt   <= '0;
          end
        S_PHASE:
          if (lvd_i && cause != C_LV) begin
            cause <= C_LV;
            cnt   <= '0;
          end else if (cnt == PH_LAST) begin
            if (!hold) begin
              st  <= S_STAB;
              cnt <= '0;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        S_STAB:
          if (lvd_i) begin
            st    <= S_PHASE;
            cause <= C_LV;
            cnt   <= '0;
          end else if (ext_low && cnt >= SETTLE) begin
            st    <= S_PHASE;
            cause <= C_PIN;
            cnt   <= '0;
          end else if (cnt == stab_last) begin
            st    <= S_RUN;
            vec_q <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        default: st <= S_RUN;
      endcase
    end
  end

  always_comb begin
    flags_nxt = flags;
    if (flg_wr_i) flags_nxt = flags_nxt & flg_wdata_i;
    if (st == S_RUN && wdg_trip_i) flags_nxt[0] = 1'b1;
    if (lvd_i) flags_nxt = 2'b10;
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) flags <= 2'b10;
    else        flags <= flags_nxt;

  assign pin_drive_n_o = !(st == S_PHASE && cause != C_PIN);
  assign core_rst_n_o  = (st == S_RUN);
  assign vec_fetch_o   = vec_q;
  assign flg_rdata_o   = flags;
endmodule

module rst_sequencer_chk (
  input logic       clk,
  input logic       por_n,
  input logic       lvd_i,
  input logic       wdg_trip_i,
  input logic       flg_wr_i,
  input logic [1:0] flg_wdata_i,
  input logic       pin_drive_n_o,
  input logic       core_rst_n_o,
  input logic       vec_fetch_o,
  input logic [1:0] flg_rdata_o
);
  p_pin_only_in_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    !pin_drive_n_o |-> !core_rst_n_o);

  p_vec_on_release_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n_o) |-> vec_fetch_o);

  p_vec_single_r6: assert property (@(posedge clk) disable iff (!por_n)
    vec_fetch_o |=> !vec_fetch_o);

  p_lv_clears_wd_r7: assert property (@(posedge clk) disable iff (!por_n)
    lvd_i |=> flg_rdata_o == 2'b10);

  p_lv_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    flg_rdata_o[1] && !(flg_wr_i && !flg_wdata_i[1]) |=> flg_rdata_o[1]);

  p_wr_one_noeffect_r9: assert property (@(posedge clk) disable iff (!por_n)
    flg_wr_i && flg_wdata_i == 2'b11 && !lvd_i && !wdg_trip_i |=> $stable(flg_rdata_o));

  p_ignore_in_reset_r10: assert property (@(posedge clk) disable iff (!por_n)
    !core_rst_n_o && !lvd_i && !flg_wr_i |=> $stable(flg_rdata_o));
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (.*);

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
  localparam int P  = 20;
  localparam int SS = 32;
  localparam int SL = 64;

  logic clk = 1'b0;
  logic por_n = 1'b0, lvd = 1'b0, wdg = 1'b0, bad = 1'b0, ext_pull_n = 1'b1;
  logic osc = 1'b0, wr = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic pin_drive_n, core_rst_n, vec_fetch;
  logic [1:0] flags;
  logic pin_sense_n;

  always #2 clk = ~clk;
  assign pin_sense_n = pin_drive_n & ext_pull_n;

  rst_sequencer #(.PHASE_CYC(P), .STAB_SHORT(SS), .STAB_LONG(SL), .PIN_SETTLE(4)) u_rst_sequencer (
    .clk(clk), .por_n(por_n), .lvd_i(lvd), .wdg_trip_i(wdg), .bad_op_i(bad),
    .pin_sense_n_i(pin_sense_n), .osc_is_resonator_i(osc), .flg_wr_i(wr),
    .flg_wdata_i(wdata), .pin_drive_n_o(pin_drive_n), .core_rst_n_o(core_rst_n),
    .vec_fetch_o(vec_fetch), .flg_rdata_o(flags));

  typedef struct {
    int         core_low;
    int         pin_low;
    logic [1:0] flg;
    string      req;
  } ep_t;

  ep_t exp_q[$];
  int checks = 0, errors = 0;
  int core_cnt = 0, pin_cnt = 0;
  logic prev_core = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int cl, input int pl, input logic [1:0] f, input string r);
    ep_t e;
    e.core_low = cl; e.pin_low = pl; e.flg = f; e.req = r;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (!por_n) begin
      core_cnt = 0; pin_cnt = 0; prev_core = 1'b0;
    end else begin
      if (!core_rst_n) core_cnt++;
      if (!pin_drive_n) pin_cnt++;
      if (core_rst_n && !prev_core) begin
        if (exp_q.size() == 0) begin
          chk("R1", "unexpected reset episode", 1, 0);
        end else begin
          ep_t e;
          e = exp_q.pop_front();
          chk(e.req, "core reset cycles", core_cnt, e.core_low);
          chk(e.req, "pin drive cycles", pin_cnt, e.pin_low);
          chk(e.req, "flags", int'(flags), int'(e.flg));
          chk("R6", "vector strobe on release", int'(vec_fetch), 1);
        end
        core_cnt = 0; pin_cnt = 0;
      end else if (vec_fetch) begin
        chk("R6", "stray vector strobe", 1, 0);
      end
      prev_core = core_rst_n;
    end
  end

  task automatic wait_run;
    @(negedge clk);
    while (!core_rst_n) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic sw_write(input logic [1:0] d, input logic [1:0] exp, input string r);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
    chk(r, "flags after write", int'(flags), int'(exp));
  endtask

  task automatic fire_lv(input int h);
    @(negedge clk); lvd = 1'b1;
    repeat (h) @(negedge clk);
    lvd = 1'b0;
  endtask

  task automatic fire_pin(input int w);
    @(negedge clk); ext_pull_n = 1'b0;
    repeat (w) @(negedge clk);
    ext_pull_n = 1'b1;
  endtask

  task automatic fire_wdg;
    @(negedge clk); wdg = 1'b1;
    @(negedge clk); wdg = 1'b0;
  endtask

  task automatic fire_bad;
    @(negedge clk); bad = 1'b1;
    @(negedge clk); bad = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R12: power-on state
    chk("R12", "core reset during por", int'(core_rst_n), 0);
    chk("R12", "pin drive during por", int'(pin_drive_n), 0);
    chk("R12", "flags during por", int'(flags), 2);
    chk("R12", "no strobe during por", int'(vec_fetch), 0);
    // counting starts at the first edge after release, so one cycle less
    push(P + SS - 1, P - 1, 2'b10, "R12");
    #1 por_n = 1'b1;
    wait_run();

    sw_write(2'b01, 2'b00, "R9");
    sw_write(2'b11, 2'b00, "R9");

    // R1: supply wins over a simultaneous watchdog trip
    push(P + SS, P, 2'b10, "R1");
    @(negedge clk); lvd = 1'b1; wdg = 1'b1;
    @(negedge clk); lvd = 1'b0; wdg = 1'b0;
    wait_run();
    sw_write(2'b00, 2'b00, "R9");

    push(P + SS, P, 2'b01, "R2");
    fire_wdg(); wait_run();

    osc = 1'b1;
    push(P + SL, P, 2'b01, "R5");
    fire_bad(); wait_run();
    chk("R8", "flags kept after illegal opcode", int'(flags), 1);

    osc = 1'b0;
    push(P + SS, 0, 2'b01, "R4");
    fire_pin(5); wait_run();

    osc = 1'b1;
    push(50 + SL, 0, 2'b01, "R4");
    fire_pin(50); wait_run();
    osc = 1'b0;

    push(P + SS, P, 2'b10, "R7");
    fire_lv(3); wait_run();

    push(P + SS, P, 2'b11, "R8");
    fire_wdg(); wait_run();
    sw_write(2'b10, 2'b10, "R9");

    push(45 + SS, 45, 2'b10, "R3");
    fire_lv(45); wait_run();

    // R10: watchdog and illegal requests during reset are ignored
    push(P + SS, P, 2'b10, "R10");
    fire_bad();
    repeat (5) @(negedge clk);
    fire_wdg();
    repeat (P) @(negedge clk);
    fire_bad();
    fire_wdg();
    wait_run();
    chk("R10", "flags after ignored requests", int'(flags), 2);

    sw_write(2'b00, 2'b00, "R9");

    // R11: supply indication 5 cycles into the settling count
    push(P + 5 + P + SS, 2 * P, 2'b10, "R11");
    @(negedge clk); bad = 1'b1;
    @(negedge clk); bad = 1'b0;
    repeat (P + 5 - 1) @(negedge clk);
    lvd = 1'b1;
    repeat (4) @(negedge clk);
    lvd = 1'b0;
    wait_run();

    chk("R1", "all expected episodes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule